// File: doc/BRIEF.md
# Translation Permission Fault Checker

This block sits after the translation lookup of a memory management unit and decides, for each access that found a matching page entry, whether the entry's permission bits allow that access. The hit flag presented to it already folds in any address-space identifier comparison, so the checker only sees "entry matched" or "no entry matched".

An instruction fetch requires execute permission, a load requires read permission and a store requires write permission. A denied access produces a one-cycle fault pulse on the clock edge after the request, along with a 5-bit cause code that identifies which permission was missing. The four data-cache maintenance operations (initialise or flush, each by index or by address) skip the check entirely. The cause code, access kind and address of the most recent fault are held in a record until the next fault overwrites them.

Top module: `tlb_perm_chk`

## Requirements
- R1: After reset, fault_o is 0, cause_o is 0, flt_kind_o is 0 and flt_addr_o is 0.
- R2: A fetch (kind 0) that hits an entry with exec_i=0 raises fault_o for exactly one cycle, on the edge after the request, with cause_o=14.
- R3: A load (kind 1) that hits an entry with read_i=0 raises a fault with cause_o=15.
- R4: A store (kind 2) that hits an entry with write_i=0 raises a fault with cause_o=16.
- R5: When hit_i=0, no fault is raised for any access kind or any permission bits.
- R6: The cache maintenance kinds (4 init-by-index, 5 init-by-address, 6 flush-by-index, 7 flush-by-address) never raise a fault. Kind 3 is reserved and also never faults.
- R7: An access that has the permission it needs raises no fault.
- R8: When a fault is raised, cause_o, flt_kind_o and flt_addr_o capture the faulting request and keep those values until the next fault.
- R9: When req_i=0, fault_o stays 0 and the held record does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| kind_i | input | 3 | Access kind code |
| addr_i | input | 32 | Virtual address of the access |
| hit_i | input | 1 | A translation entry matched |
| exec_i | input | 1 | Execute permission of the matched entry |
| read_i | input | 1 | Read permission of the matched entry |
| write_i | input | 1 | Write permission of the matched entry |
| fault_o | output | 1 | One-cycle permission fault pulse |
| cause_o | output | 5 | Cause code of the last fault |
| flt_kind_o | output | 3 | Access kind of the last fault |
| flt_addr_o | output | 32 | Address of the last fault |

## Verification
A wrong decision shows up on fault_o one edge after the request. A wrong cause or a record that is updated at the wrong time shows up on the record ports in the same cycle. The bench sweeps every kind with every combination of hit and permission bits. After each request it compares the pulse and the whole record with values computed from the requirements, so a corrupted record from an earlier step is caught at the next comparison.

// File: rtl/tlb_perm_pkg.sv
package tlb_perm_pkg;
  localparam int unsigned KIND_W  = 3;
  localparam int unsigned CAUSE_W = 5;

  typedef enum logic [KIND_W-1:0] {
    ACC_FETCH = 3'd0,
    ACC_LOAD  = 3'd1,
    ACC_STORE = 3'd2,
    ACC_RSVD  = 3'd3,
    ACC_INIT_IDX  = 3'd4,
    ACC_INIT_ADR  = 3'd5,
    ACC_FLSH_IDX  = 3'd6,
    ACC_FLSH_ADR  = 3'd7
  } acc_kind_e;

  localparam logic [CAUSE_W-1:0] CAUSE_X = 5'd14;
  localparam logic [CAUSE_W-1:0] CAUSE_R = 5'd15;
  localparam logic [CAUSE_W-1:0] CAUSE_W_ = 5'd16;
endpackage

// File: rtl/tlb_perm_decide.sv
module tlb_perm_decide
  import tlb_perm_pkg::*;
(
  input  logic [KIND_W-1:0]  kind_i,
  input  logic               hit_i,
  input  logic               exec_i,
  input  logic               read_i,
  input  logic               write_i,
  output logic               deny_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    deny_o  = 1'b0;
    cause_o = '0;
    if (hit_i) begin
      unique case (acc_kind_e'(kind_i))
        ACC_FETCH: begin deny_o = ~exec_i;  cause_o = CAUSE_X;  end
        ACC_LOAD:  begin deny_o = ~read_i;  cause_o = CAUSE_R;  end
        ACC_STORE: begin deny_o = ~write_i; cause_o = CAUSE_W_; end
        default:   begin deny_o = 1'b0;     cause_o = '0;       end // cache ops, reserved
      endcase
    end
  end

  always_comb begin
    if (deny_o) assert (hit_i) else $error("p_deny_needs_hit_r5");
    if (kind_i >= 3'd3) assert (!deny_o) else $error("p_cache_ops_bypass_r6");
  end
endmodule

// File: rtl/tlb_perm_rec.sv
module tlb_perm_rec
  import tlb_perm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [KIND_W-1:0]  kind_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [KIND_W-1:0]  kind_o,
  output logic [ADDR_W-1:0]  addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      cause_o <= '0;
      kind_o  <= '0;
      addr_o  <= '0;
    end else begin
      fault_o <= cap_i;
      if (cap_i) begin
        cause_o <= cause_i;
        kind_o  <= kind_i;
        addr_o  <= addr_i;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(cause_o) && $stable(kind_o) && $stable(addr_o));
  p_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> fault_o);
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_perm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hit_i,
  input  logic              exec_i,
  input  logic              read_i,
  input  logic              write_i,
  output logic              fault_o,
  output logic [4:0]        cause_o,
  output logic [2:0]        flt_kind_o,
  output logic [ADDR_W-1:0] flt_addr_o
);
  logic               deny;
  logic [CAUSE_W-1:0] deny_cause;

  tlb_perm_decide u_dec (
    .kind_i (kind_i),
    .hit_i  (hit_i),
    .exec_i (exec_i),
    .read_i (read_i),
    .write_i(write_i),
    .deny_o (deny),
    .cause_o(deny_cause)
  );

  tlb_perm_rec #(.ADDR_W(ADDR_W)) u_rec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (req_i & deny),
    .cause_i(deny_cause),
    .kind_i (kind_i),
    .addr_i (addr_i),
    .fault_o(fault_o),
    .cause_o(cause_o),
    .kind_o (flt_kind_o),
    .addr_o (flt_addr_o)
  );

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !fault_o);
  p_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> !fault_o);
  p_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (cause_o == 5'd14 || cause_o == 5'd15 || cause_o == 5'd16));
  p_granted_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 3'd2 && write_i) |=> !fault_o);
endmodule

// File: tb/tlb_perm_chk_test.sv
module tlb_perm_chk_test;
  localparam int CLK_PER = 10;

  logic clk = 0, rst_n = 0;
  logic req = 0, hit = 0, ex = 0, rd = 0, wr = 0;
  logic [2:0] kind = 0;
  logic [31:0] addr = 0;
  logic fault;
  logic [4:0] cause;
  logic [2:0] fkind;
  logic [31:0] faddr;
  int total = 0, bad = 0;
  logic [4:0] e_cause = 0;
  logic [2:0] e_kind = 0;
  logic [31:0] e_addr = 0;

  always #(CLK_PER/2) clk = ~clk;

  tlb_perm_chk uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .hit_i(hit), .exec_i(ex), .read_i(rd), .write_i(wr),
    .fault_o(fault), .cause_o(cause), .flt_kind_o(fkind), .flt_addr_o(faddr)
  );

  task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req_tag, act, exp);
    end
  endtask

  task automatic chk_rec(string req_tag);
    chk(req_tag, {59'd0, cause}, {59'd0, e_cause});
    chk(req_tag, {61'd0, fkind}, {61'd0, e_kind});
    chk(req_tag, {32'd0, faddr}, {32'd0, e_addr});
  endtask

  initial begin
    #(CLK_PER*50000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PER*2 + 1);
    // R1 reset state
    chk("R1", {63'd0, fault}, 64'd0);
    chk_rec("R1");
    rst_n = 1;
    @(negedge clk);
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 8; k++)
        for (int v = 0; v < 16; v++) begin
          logic exp_f;
          logic [4:0] c;
          string tag;
          req = r[0]; kind = k[2:0]; hit = v[3]; ex = v[2]; rd = v[1]; wr = v[0];
          addr = {k[7:0], v[7:0], 16'h1000} + 32'(r);
          exp_f = 0; c = 0;
          if (r == 1 && v[3]) begin
            if (k == 0 && !v[2]) begin exp_f = 1; c = 5'd14; end
            if (k == 1 && !v[1]) begin exp_f = 1; c = 5'd15; end
            if (k == 2 && !v[0]) begin exp_f = 1; c = 5'd16; end
          end
          if (r == 0) tag = "R9";
          else if (!v[3]) tag = "R5";
          else if (k >= 3) tag = "R6";
          else if (!exp_f) tag = "R7";
          else if (k == 0) tag = "R2";
          else if (k == 1) tag = "R3";
          else tag = "R4";
          if (exp_f) begin e_cause = c; e_kind = k[2:0]; e_addr = addr; end
          @(negedge clk);
          req = 0;
          chk(tag, {63'd0, fault}, {63'd0, exp_f});
          chk_rec(exp_f ? "R8" : tag);
          @(negedge clk);
          // R2 single-cycle pulse, R8 record held
          chk("R2", {63'd0, fault}, 64'd0);
          chk_rec("R8");
        end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule